// File: doc/BRIEF.md
# EDO Page-Mode Burst Read Sequencer

This block turns one host request (row, starting column, byte count) into a single open-row burst of reads on an asynchronous DRAM with an extended-data-out page mode. The row strobe is lowered once with the row on the multiplexed address bus. The column strobe then pulses once per byte, and each pulse carries the next column. Because the part keeps its output driven after the column strobe rises, the byte for a column is taken at the clock edge that ends that column's strobe-high phase. That same edge starts the next column's strobe-low phase, so the column strobe runs at the page period and does not wait out a full access time on every byte.

Each captured byte goes to the host with a one-cycle valid strobe, in column order. The burst is cut short when it would run past the last column of the row, or when it would keep the row strobe low longer than the row-active limit allows. The limit is given as a cycle count, and the largest legal byte count is derived from it. A one-cycle completion pulse and a short-burst flag report the end of the burst. After the burst the row strobe is held low for a closing gap, then kept high for the precharge time before the block accepts new work. Write enable stays inactive throughout. Output enable is active exactly while the row is open.

Top module: `edo_page_reader`

## Requirements
- R1: While reset is high, ras_n, cas_n, oe_n and we_n are 1, busy is 0 and rd_valid is 0.
- R2: A start accepted in idle drives ras_n low with the row on addr (zero-extended). The first cas_n fall comes exactly T_RCD cycles after the ras_n fall.
- R3: Each cas_n low phase lasts exactly T_CL cycles, and each high phase between two columns lasts exactly T_CP cycles. addr holds the column unchanged while cas_n is low, and cas_n is never low while ras_n is high.
- R4: The columns presented on successive cas_n falls are col, col+1, col+2, ... with no gaps.
- R5: Each column yields exactly one rd_valid pulse. Its rd_data is dq as sampled on the clock edge that ends that column's cas_n-high phase, and bytes leave in column order.
- R6: The number of bytes is min(len, 2^COL_W - col, MAX_BURST), where MAX_BURST = (RAS_LIMIT_CYC - T_RCD - T_RHCP) / (T_CL + T_CP). short_burst is 1 at the done pulse exactly when that number is below len.
- R7: A burst that would pass column 2^COL_W - 1 stops after that column, does not wrap to column 0, and flags short_burst.
- R8: A len above MAX_BURST (with room left in the row) yields exactly MAX_BURST bytes and flags short_burst.
- R9: we_n is always 1, and oe_n equals ras_n in every cycle, so the data bus is released when the row closes.
- R10: ras_n rises exactly T_CP + T_RHCP cycles after the last cas_n rise. done is a one-cycle pulse in the first cycle with ras_n high. ras_n then stays high for at least T_RP cycles before it falls again.
- R11: A start with len equal to 0, or a start while busy, is ignored: no row strobe is issued and any running burst goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken in idle when len_i is non-zero |
| row_i | input | ROW_W | Row to open |
| col_i | input | COL_W | First column |
| len_i | input | LEN_W | Requested byte count |
| busy | output | 1 | Burst or closing precharge in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| short_burst | output | 1 | Burst was cut below the request (read at done) |
| rd_valid | output | 1 | rd_data holds a new byte |
| rd_data | output | DATA_W | Captured read byte |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held inactive |
| oe_n | output | 1 | Output enable, active low |
| addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq | input | DATA_W | Read data from the memory |

## Verification
The bench builds the block with 6 row bits, 5 column bits (32 columns), a 6-bit length and a row-active limit of 49 cycles, which gives MAX_BURST = 10. With these values both early-stop causes fall within ordinary stimulus. A start column near 31 hits the row end within a few bytes, and any length from 11 to 14 starting low in the row hits the cap. The default timing cycle counts are kept, so every strobe width, the closing gap and the precharge are measured at the pins against the exact cycle counts in R2, R3 and R10.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_CLO,
        ST_CHI,
        ST_TAIL,
        ST_PRE
    } edo_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic oe_n;
    } edo_strobe_t;

    // smallest of requested count, columns left in the row, and row-active cap
    function automatic int burst_span(input int want, input int room, input int cap);
        int s;
        s = want;
        if (room < s) s = room;
        if (cap < s) s = cap;
        return s;
    endfunction

endpackage

// File: rtl/edo_timer.sv
`timescale 1ns/1ps
module edo_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/edo_col_seq.sv
`timescale 1ns/1ps
module edo_col_seq #(
    parameter int COL_W = 5,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [COL_W-1:0] col0,
    input  logic [LEN_W-1:0] cnt0,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic             last
);
    logic [LEN_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            rem <= '0;
        end else if (init) begin
            col <= col0;
            rem <= cnt0;
        end else if (step) begin
            col <= col + 1'b1;
            rem <= rem - 1'b1;
        end
    end

    assign last = (rem == LEN_W'(1));
endmodule

// File: rtl/edo_capture.sv
`timescale 1ns/1ps
module edo_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= cap;
            if (cap) data <= dq;
        end
    end
endmodule

// File: rtl/edo_page_reader.sv
`timescale 1ns/1ps
module edo_page_reader
    import edo_pkg::*;
#(
    parameter int ROW_W         = 13,
    parameter int COL_W         = 11,
    parameter int LEN_W         = 14,
    parameter int DATA_W        = 8,
    parameter int T_RCD         = 3,
    parameter int T_CL          = 2,
    parameter int T_CP          = 2,
    parameter int T_RHCP        = 6,
    parameter int T_RP          = 6,
    parameter int RAS_LIMIT_CYC = 40000,
    localparam int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              busy,
    output logic              done,
    output logic              short_burst,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq
);
    localparam int COLS      = 1 << COL_W;
    localparam int PAGE_CYC  = T_CL + T_CP;
    localparam int MAX_BURST = (RAS_LIMIT_CYC - T_RCD - T_RHCP) / PAGE_CYC;
    localparam int TW        = $clog2(T_RCD + T_CL + T_CP + T_RHCP + T_RP + 1);

    edo_state_e        st;
    edo_strobe_t       stb;
    logic [ROW_W-1:0]  row_q;
    logic              done_q;
    logic              short_q;

    logic              accept;
    logic              tmr_ld;
    logic [TW-1:0]     tmr_val;
    logic              t_zero;
    logic              col_step;
    logic              col_last;
    logic [COL_W-1:0]  col_cur;
    logic              cap;
    logic [LEN_W-1:0]  span_c;
    logic              short_c;

    // burst size decided once, at acceptance
    always_comb begin
        int room;
        int span;
        room    = COLS - int'(col_i);
        span    = burst_span(int'(len_i), room, MAX_BURST);
        span_c  = LEN_W'(span);
        short_c = (span < int'(len_i));
    end

    assign accept = start && (len_i != '0) && (st == ST_IDLE);

    always_comb begin
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        col_step = 1'b0;
        cap      = 1'b0;
        case (st)
            ST_IDLE: if (accept) begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(T_RCD - 1);
            end
            ST_ROW: if (t_zero) begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(T_CL - 1);
            end
            ST_CLO: if (t_zero) begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(T_CP - 1);
            end
            ST_CHI: if (t_zero) begin
                cap    = 1'b1;
                tmr_ld = 1'b1;
                if (!col_last) begin
                    col_step = 1'b1;
                    tmr_val  = TW'(T_CL - 1);
                end else begin
                    tmr_val  = TW'(T_RHCP - 1);
                end
            end
            ST_TAIL: if (t_zero) begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(T_RP - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            stb     <= '{ras_n: 1'b1, cas_n: 1'b1, oe_n: 1'b1};
            row_q   <= '0;
            done_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (accept) begin
                    st        <= ST_ROW;
                    stb.ras_n <= 1'b0;
                    stb.oe_n  <= 1'b0;
                    row_q     <= row_i;
                    short_q   <= short_c;
                end
                ST_ROW: if (t_zero) begin
                    st        <= ST_CLO;
                    stb.cas_n <= 1'b0;
                end
                ST_CLO: if (t_zero) begin
                    st        <= ST_CHI;
                    stb.cas_n <= 1'b1;
                end
                ST_CHI: if (t_zero) begin
                    if (!col_last) begin
                        st        <= ST_CLO;
                        stb.cas_n <= 1'b0;
                    end else begin
                        st <= ST_TAIL;
                    end
                end
                ST_TAIL: if (t_zero) begin
                    st        <= ST_PRE;
                    stb.ras_n <= 1'b1;
                    stb.oe_n  <= 1'b1;
                    done_q    <= 1'b1;
                end
                ST_PRE: if (t_zero) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    edo_timer #(.TW(TW)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(tmr_ld),
        .val (tmr_val),
        .zero(t_zero)
    );

    edo_col_seq #(.COL_W(COL_W), .LEN_W(LEN_W)) u_cols (
        .clk (clk),
        .rst (rst),
        .init(accept),
        .col0(col_i),
        .cnt0(span_c),
        .step(col_step),
        .col (col_cur),
        .last(col_last)
    );

    edo_capture #(.DATA_W(DATA_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .dq   (dq),
        .data (rd_data),
        .valid(rd_valid)
    );

    assign ras_n       = stb.ras_n;
    assign cas_n       = stb.cas_n;
    assign oe_n        = stb.oe_n;
    assign we_n        = 1'b1;
    assign busy        = (st != ST_IDLE);
    assign done        = done_q;
    assign short_burst = short_q;
    assign addr        = (st == ST_CLO || st == ST_CHI) ? ADDR_W'(col_cur) : ADDR_W'(row_q);
endmodule

// File: rtl/edo_page_reader_chk.sv
`timescale 1ns/1ps
module edo_page_reader_chk #(
    parameter int ADDR_W = 13,
    parameter int T_CL   = 2,
    parameter int T_CP   = 2,
    parameter int T_RHCP = 6,
    parameter int T_RP   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ras_n,
    input logic              cas_n,
    input logic              oe_n,
    input logic              busy,
    input logic              done,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] addr
);
    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;
    logic [15:0] rh_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '1;
            rh_cnt <= '1;
        end else begin
            lo_cnt <= !cas_n ? ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1) : '0;
            hi_cnt <=  cas_n ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1) : '0;
            rh_cnt <=  ras_n ? ((rh_cnt == '1) ? rh_cnt : rh_cnt + 1'b1) : '0;
        end
    end

    p_cas_in_row_r3: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    p_cas_low_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> (lo_cnt >= 16'(T_CL)));

    p_cas_high_width_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (hi_cnt >= 16'(T_CP)));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && !$past(cas_n)) |-> $stable(addr));

    p_valid_in_burst_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    p_oe_tracks_ras_r9: assert property (@(posedge clk) disable iff (rst)
        oe_n == ras_n);

    p_close_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (hi_cnt >= 16'(T_CP + T_RHCP)));

    p_precharge_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (rh_cnt >= 16'(T_RP)));

    p_done_row_closed_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> ras_n);
endmodule

bind edo_page_reader edo_page_reader_chk #(
    .ADDR_W(ADDR_W),
    .T_CL  (T_CL),
    .T_CP  (T_CP),
    .T_RHCP(T_RHCP),
    .T_RP  (T_RP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .oe_n    (oe_n),
    .busy    (busy),
    .done    (done),
    .rd_valid(rd_valid),
    .addr    (addr)
);

// File: tb/tb_edo_page_reader.sv
`timescale 1ns/1ps
module tb_edo_page_reader;
    localparam int ROW_W = 6;
    localparam int COL_W = 5;
    localparam int LEN_W = 6;
    localparam int DW    = 8;
    localparam int T_RCD = 3, T_CL = 2, T_CP = 2, T_RHCP = 6, T_RP = 6;
    localparam int RLIM  = 49;
    localparam int AW    = 6;
    localparam int COLS  = 32;
    localparam int MAXB  = (RLIM - T_RCD - T_RHCP) / (T_CL + T_CP);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [ROW_W-1:0] row_i = '0;
    logic [COL_W-1:0] col_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic busy, done, short_burst, rd_valid, ras_n, cas_n, we_n, oe_n;
    logic [DW-1:0] rd_data, dq;
    logic [AW-1:0] addr;

    always #2.5 clk = ~clk;

    edo_page_reader #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .DATA_W(DW),
        .T_RCD(T_RCD), .T_CL(T_CL), .T_CP(T_CP), .T_RHCP(T_RHCP), .T_RP(T_RP),
        .RAS_LIMIT_CYC(RLIM)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .row_i(row_i), .col_i(col_i), .len_i(len_i),
        .busy(busy), .done(done), .short_burst(short_burst), .rd_valid(rd_valid),
        .rd_data(rd_data), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq(dq)
    );

    function automatic logic [7:0] mem_f(input int r, input int c);
        return 8'(((r * 37) + (c * 11)) ^ 90);
    endfunction

    // memory model and pin monitor, both at the falling clock edge
    int cyc = 0, t_ras_fall = 0, t_ras_rise = 0, t_cas_fall = 0, t_cas_rise = 0;
    int ras_falls = 0, ncas = 0, nv = 0, done_cnt = 0;
    int err_rcd = 0, err_cl = 0, err_cp = 0, err_tail = 0, err_rp = 0, err_pin = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, seen_rise = 1'b0, first_cas = 1'b0;
    logic short_l = 1'b0;
    logic [AW-1:0] row_l = '0, col_l = '0;
    int got [256];
    int colq [256];

    assign dq = mem_f(int'(row_l), int'(col_l));

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (prev_ras && !ras_n) begin
                if (seen_rise && (cyc - t_ras_rise) < T_RP) err_rp++;
                t_ras_fall = cyc; row_l = addr; ras_falls++; first_cas = 1'b1;
            end
            if (!prev_ras && ras_n) begin
                if ((cyc - t_cas_rise) != (T_CP + T_RHCP) || !done) err_tail++;
                t_ras_rise = cyc; seen_rise = 1'b1;
            end
            if (prev_cas && !cas_n) begin
                if (first_cas) begin
                    if ((cyc - t_ras_fall) != T_RCD) err_rcd++;
                end else if ((cyc - t_cas_rise) != T_CP) err_cp++;
                first_cas = 1'b0;
                col_l = addr; colq[ncas & 255] = int'(addr); ncas++; t_cas_fall = cyc;
            end
            if (!prev_cas && cas_n) begin
                if ((cyc - t_cas_fall) != T_CL) err_cl++;
                t_cas_rise = cyc;
            end
            if (!cas_n && !prev_cas && addr != col_l) err_cl++;
            if (we_n !== 1'b1 || oe_n !== ras_n || (!cas_n && ras_n)) err_pin++;
            if (rd_valid) begin got[nv & 255] = int'(rd_data); nv++; end
            if (done) begin done_cnt++; short_l = short_burst; end
            prev_ras = ras_n; prev_cas = cas_n;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_burst(input int row, input int col, input int len, input bit poke);
        int b_nv, b_ncas, b_rf, b_done;
        int e_rcd, e_cl, e_cp, e_tail, e_rp, e_pin;
        int n_exp, room, k;
        bit sh_exp;
        string tag;
        @(negedge clk);
        b_nv = nv; b_ncas = ncas; b_rf = ras_falls; b_done = done_cnt;
        e_rcd = err_rcd; e_cl = err_cl; e_cp = err_cp; e_tail = err_tail; e_rp = err_rp; e_pin = err_pin;
        row_i = ROW_W'(row); col_i = COL_W'(col); len_i = LEN_W'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: start while busy must be ignored
            repeat (T_RCD + 3) @(negedge clk);
            row_i = ~ROW_W'(row); col_i = '0; len_i = LEN_W'(5); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (done_cnt == b_done && k < 3000) begin @(negedge clk); k++; end
        chk(k < 3000, "R10 done reached", k, 3000);
        k = 0;
        while (busy && k < 100) begin @(negedge clk); k++; end
        repeat (2) @(negedge clk);

        room  = COLS - col;
        n_exp = len;
        if (room < n_exp) n_exp = room;
        if (MAXB < n_exp) n_exp = MAXB;
        sh_exp = (n_exp < len);
        if (room < len && room <= MAXB) tag = "R7";
        else if (MAXB < len) tag = "R8";
        else tag = "R6";

        chk((nv - b_nv) == n_exp, {tag, " byte count"}, nv - b_nv, n_exp);
        chk((ncas - b_ncas) == n_exp, "R3 column strobe count", ncas - b_ncas, n_exp);
        chk(short_l == sh_exp, {tag, " short flag"}, int'(short_l), int'(sh_exp));
        chk((ras_falls - b_rf) == 1, "R11 one row strobe per request", ras_falls - b_rf, 1);
        chk(int'(row_l) == row, "R2 row address", int'(row_l), row);
        for (int i = 0; i < n_exp && i < (ncas - b_ncas); i++)
            chk(colq[(b_ncas + i) & 255] == col + i, "R4 column sequence", colq[(b_ncas + i) & 255], col + i);
        for (int i = 0; i < n_exp && i < (nv - b_nv); i++)
            chk(got[(b_nv + i) & 255] == int'(mem_f(row, col + i)), "R5 read data",
                got[(b_nv + i) & 255], int'(mem_f(row, col + i)));
        chk(err_rcd == e_rcd, "R2 row-to-column delay errors", err_rcd - e_rcd, 0);
        chk(err_cl == e_cl, "R3 strobe-low width/address hold errors", err_cl - e_cl, 0);
        chk(err_cp == e_cp, "R3 strobe-high width errors", err_cp - e_cp, 0);
        chk(err_tail == e_tail, "R10 closing gap/done errors", err_tail - e_tail, 0);
        chk(err_rp == e_rp, "R10 precharge errors", err_rp - e_rp, 0);
        chk(err_pin == e_pin, "R9 we_n/oe_n errors", err_pin - e_pin, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk((ras_falls - b_rf) == 1 && !busy, "R11 busy start dropped", ras_falls - b_rf, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_v, b_rf;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ras_n && cas_n && oe_n && we_n, "R1 strobes in reset",
            int'({ras_n, cas_n, oe_n, we_n}), 15);
        chk(!busy && !rd_valid, "R1 busy/valid in reset", int'({busy, rd_valid}), 0);
        rst = 1'b0;
        seed_v = $urandom(32'h00C0FFEE);

        run_burst(5, 0, 1, 1'b0);      // single byte
        run_burst(17, 31, 3, 1'b0);    // R7 last column only
        run_burst(9, 28, 8, 1'b0);     // R7 four bytes then stop
        run_burst(40, 0, 12, 1'b0);    // R8 cap at MAXB
        run_burst(63, 22, 10, 1'b0);   // exactly fits row and cap
        run_burst(33, 3, 6, 1'b1);     // R11 start while busy

        // R11: zero length start ignored
        @(negedge clk);
        b_rf = ras_falls;
        row_i = 6'd7; col_i = 5'd4; len_i = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk(ras_falls == b_rf && !busy && ras_n, "R11 zero length ignored", ras_falls - b_rf, 0);

        for (int n = 0; n < 24; n++)
            run_burst(int'($urandom % 64), int'($urandom % 32), 1 + int'($urandom % 14), 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule